// File: doc/BRIEF.md
# Backlight Fade Ramp Controller

This block holds the 5-bit current code shared by a bank of backlight sinks and moves it gradually toward a newly written target. With fading enabled, each accepted write starts a ramp: the level moves one code at a time, up or down, and one step is taken per step interval. A 2-bit rate field chooses an interval of 32, 24, 16 or 8 ms. A parameterised prescaler turns the system clock into a millisecond tick, and this tick is the time base for those intervals.

A write that arrives while a ramp is running is dropped. The rate field, on the other hand, may be changed during a ramp, and the new value is used from the next interval onward. If fade-enable is cleared in the middle of a ramp, the ramp is abandoned and the level jumps straight to the target. If fade-enable is already clear when a write arrives, the written code is applied at once. Each of the four sink outputs carries the shared level while its own enable bit is high and carries zero while it is low.

Top module: `bl_fade_ctrl`

## Requirements
- R1: The step interval in milliseconds follows the rate field: 2'b11 gives 8 ms, 2'b10 gives 16 ms, 2'b01 gives 24 ms and 2'b00 gives 32 ms. One millisecond lasts CLK_PER_MS clock cycles.
- R2: Every step moves the level by exactly one code toward the target. A ramp therefore takes as many steps as the absolute difference between the starting code and the target.
- R3: While busy_o is high, a write on wr_en_i is dropped. The ramp continues to the target it had before, and that write has no later effect.
- R4: If fade_en_i is low at an edge while busy_o is high, level_o takes the target value at that edge and busy_o goes low.
- R5: With fade_en_i low and busy_o low, a write sets level_o to wr_level_i at the next edge, and busy_o stays low.
- R6: The rate is sampled when a ramp starts and again at every step. A change to rate_i made partway through an interval does not alter that interval. It governs the intervals that follow.
- R7: Reset (rst_ni low, asynchronous) forces level_o to 0, busy_o to 0 and every sink output to 0, and it also ends any ramp in progress.
- R8: Sink i drives sink_level_o[5*i+4:5*i]. That slice equals level_o when sink_en_i[i] is 1 and equals 0 when sink_en_i[i] is 0.
- R9: A fade write whose code differs from level_o raises busy_o at the next edge and leaves level_o unchanged at that edge. busy_o then stays high until the edge at which level_o reaches the target. A fade write whose code equals level_o does not raise busy_o.
- R10: When a fade write is accepted at edge E, the first step occurs at edge E + I*CLK_PER_MS, where I is the interval in ms. Each following step comes one full interval after the step before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Level write strobe, one cycle |
| wr_level_i | input | 5 | Target code carried by the write |
| fade_en_i | input | 1 | 1 = ramp to new codes, 0 = apply them at once |
| rate_i | input | 2 | Step interval select (see R1) |
| sink_en_i | input | NUM_SINKS | Per-sink enables, active high |
| level_o | output | 5 | Present shared level code |
| busy_o | output | 1 | High while a ramp is running |
| sink_level_o | output | 5*NUM_SINKS | Gated level for each sink, sink i in bits [5i+4:5i] |

## Verification
The bench predicts the exact clock edge of every step in each ramp and compares each level change against that prediction. An off-by-one in the prescaler or in the interval counter therefore shows up as a timing miscompare, and so does a timer that is not restarted when a ramp begins. One test changes the rate just after a step: a design that applies the new rate in the middle of an interval, or that ignores it entirely, lands its following steps on the wrong edges. Other tests cover a write made during a ramp (an accepting design jumps or changes direction), cancellation (a design that keeps stepping never snaps to the target) and a write equal to the present level (a faulty design raises busy with nothing to do). Each of the four rate codes is exercised in at least one ramp.

// File: rtl/bl_fade_pkg.sv
package bl_fade_pkg;

    localparam int LVL_W      = 5;
    localparam int RATE_W     = 2;
    localparam int IVL_W      = 6;
    localparam int MS_UNIT    = 8;
    localparam int RATE_CODES = 4;

    typedef logic [LVL_W-1:0] level_t;
    typedef logic [RATE_W-1:0] rate_t;
    typedef logic [IVL_W-1:0] ivl_t;

    typedef struct packed {
        level_t level;
        level_t target;
        logic   busy;
    } ramp_state_t;

    typedef struct packed {
        ivl_t ms;
        ivl_t ivl;
    } ivl_state_t;

    // Rate code 0 is the slowest interval; each code step removes one unit.
    function automatic ivl_t rate_to_ms(rate_t r);
        return IVL_W'((RATE_CODES - int'(r)) * MS_UNIT);
    endfunction

endpackage

// File: rtl/bl_fade_tick.sv
module bl_fade_tick #(
    parameter int CLK_PER_MS = 250000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = $clog2(CLK_PER_MS + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;

    assign tick_o = (st_q.cnt == PW'(CLK_PER_MS - 1));

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.cnt = '0;
        end else if (tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + PW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bl_fade_interval.sv
module bl_fade_interval
    import bl_fade_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  start_i,
    input  logic  busy_i,
    input  logic  tick_i,
    input  rate_t rate_i,
    output logic  step_o
);
    ivl_state_t st_d, st_q;

    assign step_o = busy_i && tick_i && (st_q.ms == st_q.ivl - IVL_W'(1));

    always_comb begin
        st_d = st_q;
        if (start_i || step_o) begin
            // New interval: restart the count and sample the rate.
            st_d.ms  = '0;
            st_d.ivl = rate_to_ms(rate_i);
        end else if (busy_i && tick_i) begin
            st_d.ms = st_q.ms + IVL_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.ms  <= '0;
            st_q.ivl <= rate_to_ms('0);
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bl_fade_ramp.sv
module bl_fade_ramp
    import bl_fade_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   wr_en_i,
    input  level_t wr_level_i,
    input  logic   fade_en_i,
    input  logic   step_i,
    output level_t level_o,
    output logic   busy_o,
    output logic   start_o
);
    ramp_state_t st_d, st_q;
    level_t      next_lvl;

    assign start_o = wr_en_i && !st_q.busy && fade_en_i && (wr_level_i != st_q.level);
    assign level_o = st_q.level;
    assign busy_o  = st_q.busy;

    always_comb begin
        st_d     = st_q;
        next_lvl = (st_q.level > st_q.target) ? st_q.level - LVL_W'(1)
                                              : st_q.level + LVL_W'(1);
        if (st_q.busy) begin
            if (!fade_en_i) begin
                st_d.level = st_q.target;
                st_d.busy  = 1'b0;
            end else if (step_i) begin
                st_d.level = next_lvl;
                if (next_lvl == st_q.target) begin
                    st_d.busy = 1'b0;
                end
            end
        end else if (wr_en_i) begin
            st_d.target = wr_level_i;
            if (!fade_en_i) begin
                st_d.level = wr_level_i;
            end else if (wr_level_i != st_q.level) begin
                st_d.busy = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/bl_fade_sinks.sv
module bl_fade_sinks
    import bl_fade_pkg::*;
#(
    parameter int NUM_SINKS = 4
) (
    input  level_t                       level_i,
    input  logic [NUM_SINKS-1:0]         en_i,
    output logic [NUM_SINKS*LVL_W-1:0]   sink_o
);
    for (genvar g = 0; g < NUM_SINKS; g++) begin : g_sink
        assign sink_o[g*LVL_W +: LVL_W] = en_i[g] ? level_i : '0;
    end

endmodule

// File: rtl/bl_fade_ctrl.sv
module bl_fade_ctrl
    import bl_fade_pkg::*;
#(
    parameter int CLK_PER_MS = 250000,
    parameter int NUM_SINKS  = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_en_i,
    input  logic [4:0]                   wr_level_i,
    input  logic                         fade_en_i,
    input  logic [1:0]                   rate_i,
    input  logic [NUM_SINKS-1:0]         sink_en_i,
    output logic [4:0]                   level_o,
    output logic                         busy_o,
    output logic [NUM_SINKS*5-1:0]       sink_level_o
);
    logic tick;
    logic start;
    logic step;

    bl_fade_tick #(.CLK_PER_MS(CLK_PER_MS)) tick_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (start),
        .tick_o (tick)
    );

    bl_fade_interval ivl_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (start),
        .busy_i  (busy_o),
        .tick_i  (tick),
        .rate_i  (rate_i),
        .step_o  (step)
    );

    bl_fade_ramp ramp_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_level_i (wr_level_i),
        .fade_en_i  (fade_en_i),
        .step_i     (step),
        .level_o    (level_o),
        .busy_o     (busy_o),
        .start_o    (start)
    );

    bl_fade_sinks #(.NUM_SINKS(NUM_SINKS)) sinks_i (
        .level_i (level_o),
        .en_i    (sink_en_i),
        .sink_o  (sink_level_o)
    );

endmodule

// File: rtl/bl_fade_ctrl_chk.sv
module bl_fade_ctrl_chk #(
    parameter int NUM_SINKS = 4
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   wr_en_i,
    input logic [4:0]             wr_level_i,
    input logic                   fade_en_i,
    input logic [NUM_SINKS-1:0]   sink_en_i,
    input logic [4:0]             level_o,
    input logic                   busy_o,
    input logic [NUM_SINKS*5-1:0] sink_level_o
);
    assert_step_one_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && fade_en_i |=> (level_o == $past(level_o)) ||
                                (level_o == $past(level_o) + 5'd1) ||
                                (level_o == $past(level_o) - 5'd1));

    assert_cancel_snap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o && !fade_en_i |=> !busy_o);

    assert_direct_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && wr_en_i && !fade_en_i |=> (level_o == $past(wr_level_i)) && !busy_o);

    assert_ramp_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && wr_en_i && fade_en_i && (wr_level_i != level_o) |=> busy_o && $stable(level_o));

    assert_no_ramp_equal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && wr_en_i && fade_en_i && (wr_level_i == level_o) |=> !busy_o);

    assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o && !wr_en_i |=> $stable(level_o) && !busy_o);

    for (genvar g = 0; g < NUM_SINKS; g++) begin : g_chk
        assert_sink_gate_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            sink_level_o[g*5 +: 5] == (sink_en_i[g] ? level_o : 5'd0));
    end

endmodule

bind bl_fade_ctrl bl_fade_ctrl_chk #(.NUM_SINKS(NUM_SINKS)) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_en_i      (wr_en_i),
    .wr_level_i   (wr_level_i),
    .fade_en_i    (fade_en_i),
    .sink_en_i    (sink_en_i),
    .level_o      (level_o),
    .busy_o       (busy_o),
    .sink_level_o (sink_level_o)
);

// File: tb/bl_fade_ctrl_tb_top.sv
`timescale 1ns/1ps
module bl_fade_ctrl_tb_top;
    localparam int N  = 4;
    localparam int NS = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          wr_en_i = 1'b0;
    logic [4:0]    wr_level_i = '0;
    logic          fade_en_i = 1'b0;
    logic [1:0]    rate_i = '0;
    logic [NS-1:0] sink_en_i = '0;
    logic [4:0]    level_o;
    logic          busy_o;
    logic [NS*5-1:0] sink_level_o;

    bl_fade_ctrl #(.CLK_PER_MS(N), .NUM_SINKS(NS)) dut_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .wr_en_i      (wr_en_i),
        .wr_level_i   (wr_level_i),
        .fade_en_i    (fade_en_i),
        .rate_i       (rate_i),
        .sink_en_i    (sink_en_i),
        .level_o      (level_o),
        .busy_o       (busy_o),
        .sink_level_o (sink_level_o)
    );

    always #2 clk_i = ~clk_i;

    int cyc = 0;
    always @(posedge clk_i) cyc <= cyc + 1;

    typedef struct {
        int    lvl;
        int    at;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   vectors = 0;
    int   miscompares = 0;
    bit   done = 1'b0;
    logic [4:0] prev_lvl = '0;

    task automatic check(string tag, int got, int exp, string what);
        vectors++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: %s got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Monitor: every level change must match the head of the scoreboard.
    always @(negedge clk_i) begin
        if (!rst_ni) begin
            prev_lvl = level_o;
        end else if (level_o != prev_lvl) begin
            vectors++;
            if (sbq.size() == 0) begin
                miscompares++;
                $display("FAIL R3: unexpected level change got %0d at cycle %0d expected no change",
                         level_o, cyc);
            end else begin
                exp_t e;
                e = sbq.pop_front();
                if (int'(level_o) != e.lvl || cyc != e.at) begin
                    miscompares++;
                    $display("FAIL %s: level got %0d at cycle %0d expected %0d at cycle %0d",
                             e.tag, level_o, cyc, e.lvl, e.at);
                end
            end
            prev_lvl = level_o;
        end
    end

    function automatic int ivl_cycles(int rate);
        return (32 - 8 * rate) * N;
    endfunction

    task automatic push(int lvl, int at, string tag);
        exp_t e;
        e.lvl = lvl;
        e.at  = at;
        e.tag = tag;
        sbq.push_back(e);
    endtask

    // Driver: expected steps of a ramp accepted at edge c+1.
    task automatic push_ramp(int from, int to, int c, int rate, int max_steps, string tag);
        int n;
        int dir;
        n   = (to > from) ? to - from : from - to;
        dir = (to > from) ? 1 : -1;
        if (n > max_steps) n = max_steps;
        for (int k = 1; k <= n; k++) begin
            push(from + dir * k, c + 1 + k * ivl_cycles(rate), tag);
        end
    endtask

    task automatic start_write(int lvl, bit fade, output int c);
        @(negedge clk_i);
        c          = cyc;
        wr_en_i    = 1'b1;
        wr_level_i = 5'(lvl);
        fade_en_i  = fade;
    endtask

    task automatic end_write();
        @(negedge clk_i);
        wr_en_i = 1'b0;
    endtask

    task automatic wait_until(int at);
        while (cyc < at) @(negedge clk_i);
    endtask

    task automatic wait_drain(string tag);
        for (int i = 0; i < 20000 && sbq.size() != 0; i++) @(negedge clk_i);
        @(negedge clk_i);
        check(tag, sbq.size(), 0, "pending expected steps");
        check(tag, int'(busy_o), 0, "busy after ramp");
        sbq.delete();
    endtask

    task automatic check_sinks(string tag, int lvl);
        for (int i = 0; i < NS; i++) begin
            check(tag, int'(sink_level_o[i*5 +: 5]), sink_en_i[i] ? lvl : 0, $sformatf("sink %0d", i));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run got no end expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int c;
        int x;
        repeat (4) @(negedge clk_i);
        #1 rst_ni = 1'b1;

        // R7: reset state
        @(negedge clk_i);
        check("R7", int'(level_o), 0, "level after reset");
        check("R7", int'(busy_o), 0, "busy after reset");
        sink_en_i = 4'b1111;
        #1;
        check_sinks("R7", 0);

        // R5: direct write with fade disabled
        start_write(17, 1'b0, c);
        push(17, c + 1, "R5");
        end_write();
        check("R5", int'(busy_o), 0, "busy on direct write");
        check_sinks("R8", 17);

        // R10/R2/R1: down ramp at rate 2'b11 (8 ms)
        rate_i = 2'd3;
        start_write(12, 1'b1, c);
        push_ramp(17, 12, c, 3, 99, "R10");
        end_write();
        check("R9", int'(busy_o), 1, "busy after fade write");
        check("R9", int'(level_o), 17, "level at ramp start");
        wait_drain("R2");

        // R3: up ramp at rate 2'b00 (32 ms); a write in the middle is dropped
        rate_i = 2'd0;
        start_write(31, 1'b1, c);
        push_ramp(12, 31, c, 0, 99, "R1");
        end_write();
        wait_until(c + 300);
        start_write(3, 1'b1, x);
        end_write();
        wait_drain("R3");
        check("R3", int'(level_o), 31, "level after locked write");

        // R1: rate 2'b10 (16 ms), sink mask changed mid-ramp
        rate_i = 2'd2;
        start_write(24, 1'b1, c);
        push_ramp(31, 24, c, 2, 99, "R1");
        end_write();
        wait_until(c + 100);
        sink_en_i = 4'b0101;
        #1;
        check_sinks("R8", int'(level_o));
        wait_drain("R1");

        // R6: rate change just after the first step
        rate_i = 2'd0;
        start_write(30, 1'b1, c);
        push(25, c + 1 + 128, "R6");
        push(26, c + 1 + 256, "R6");
        for (int k = 1; k <= 4; k++) push(26 + k, c + 1 + 256 + 32 * k, "R6");
        end_write();
        wait_until(c + 1 + 128 + 3);
        rate_i = 2'd3;
        wait_drain("R6");

        // R4: cancel a ramp partway through
        start_write(10, 1'b1, c);
        push_ramp(30, 10, c, 3, 3, "R4");
        end_write();
        wait_until(c + 1 + 96 + 5);
        fade_en_i = 1'b0;
        push(10, cyc + 1, "R4");
        @(negedge clk_i);
        check("R4", int'(busy_o), 0, "busy after cancel");
        check("R4", int'(level_o), 10, "level after cancel");
        wait_drain("R4");

        // R9: fade write equal to the present level
        start_write(10, 1'b1, c);
        end_write();
        check("R9", int'(busy_o), 0, "busy on equal write");
        repeat (40) @(negedge clk_i);
        check("R9", int'(level_o), 10, "level after equal write");

        // R1: rate 2'b01 (24 ms)
        rate_i = 2'd1;
        start_write(8, 1'b1, c);
        push_ramp(10, 8, c, 1, 99, "R1");
        end_write();
        wait_drain("R1");

        // R8: alternate sink mask
        sink_en_i = 4'b1010;
        #1;
        check_sinks("R8", 8);

        // R7: reset in the middle of a ramp
        start_write(20, 1'b1, c);
        end_write();
        repeat (10) @(negedge clk_i);
        #1 rst_ni = 1'b0;
        @(negedge clk_i);
        check("R7", int'(level_o), 0, "level after mid-ramp reset");
        check("R7", int'(busy_o), 0, "busy after mid-ramp reset");
        check_sinks("R7", 0);
        #1 rst_ni = 1'b1;
        repeat (200) @(negedge clk_i);
        check("R7", int'(level_o), 0, "level stays after reset");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule